// File: doc/BRIEF.md
# UART Receive Interrupt and Line Status Unit

This block is the host-facing half of a 16550-style UART receive channel. A serial deserializer hands it one parallel byte at a time, together with three per-byte error flags (parity, framing, break) and a tick that marks each elapsed character time. The block queues the bytes and their flags in a receive FIFO. It presents the usual register set on an asynchronous-style host bus with active-low chip select, read and write strobes and a 3-bit address. From the FIFO state it produces the interrupt identification value, the line status byte, an active-high interrupt output and an active-low receive-ready DMA request.

Reading the receive holding register is the only host action that retires data. It clears both the data-available and the character-timeout conditions. A read that arrives after the FIFO is already empty must leave the interrupt deasserted. The receive-ready request follows its own rules, separate from the interrupt output. In single-transfer mode it tracks FIFO occupancy. In multi-transfer mode it asserts at the trigger level or on a timeout, holds until the FIFO is drained, and drops while an errored byte is queued.

Top module: `uart_rx_host`

## Requirements
- R1: After reset the interrupt identification register (address 2) reads 0x01. Once FIFO control bit 0 is set it reads 0xC1 with nothing pending. Line status (address 5) reads 0x60 with nothing received. irq is 0 and rxrdy_n is 1.
- R2: A register access takes effect only while cs_n and rd_n (or wr_n) are both low. The order in which the two strobes fall or rise does not matter. One overlap of the two strobes performs exactly one access, however many cycles it lasts.
- R3: With line control (address 3) bit 7 set, addresses 0 and 1 read and write the low and high divisor bytes, and baud_div outputs {high, low}. With bit 7 clear, the same addresses give the receive data and interrupt enable registers again.
- R4: A write to FIFO control (address 2) with bit 0 set enables the FIFOs. Bit 1 empties the receive FIFO. Bits 7:6 select a trigger level of 1, 4, 8 or 14 bytes for the codes 00, 01, 10 and 11.
- R5: With interrupt enable bit 0 set, a FIFO fill at or above the trigger level raises irq, and the identification low nibble reads 0x4.
- R6: When at least one byte is queued and four character ticks pass with no new byte and no receive-data read, a timeout is pending. The identification low nibble then reads 0xC, and irq rises if enable bit 0 is set.
- R7: A receive-data read clears a pending timeout. A receive-data read of an already empty FIFO keeps the timeout and irq cleared, and later ticks raise nothing.
- R8: Line status bit 0 is 1 while the FIFO holds data and reads 0 once the FIFO is emptied.
- R9: Line status bits 2, 3 and 4 show the parity, framing and break flags of the byte at the FIFO head. Bit 7 is 1 while any queued byte carries an error flag.
- R10: With enable bit 2 set, an errored head byte gives identification 0x6. This source has priority over data-available and timeout.
- R11: irq is the OR of the enabled pending sources. With both enable bits clear, irq stays 0.
- R12: With FIFO control bit 3 clear, rxrdy_n is low exactly while the FIFO holds data.
- R13: With FIFO control bit 3 set, rxrdy_n goes low when the trigger level is reached or a timeout is pending. It stays low until a read empties the FIFO, and it is forced high while any queued byte carries an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while a read overlap is active |
| rx_valid | input | 1 | Deserializer byte strobe |
| rx_data | input | 8 | Received byte |
| rx_err | input | 3 | Per-byte flags: bit 0 parity, bit 1 framing, bit 2 break |
| char_tick | input | 1 | One pulse per character time |
| irq | output | 1 | Active-high interrupt |
| rxrdy_n | output | 1 | Active-low receive-ready DMA request |
| baud_div | output | 16 | Stored divisor value |

## Verification
The bench first drives a timeout and clears it with a receive-data read. It then keeps reading the empty FIFO and keeps ticking. A design that still counts timeout ticks with nothing queued, or that never clears the timeout on an empty read, leaves irq stuck high with identification 0xCC. The bench holds the strobes low over several cycles and lowers them in both orders. A design that acts on level rather than on the start of the overlap pops several bytes for one read. A design that ignores chip select pops on a read strobe alone. In multi-transfer DMA mode the bench drains the FIFO below the trigger level and queues an errored byte. A request that simply mirrors the trigger comparison drops too early, and one that ignores error flags stays asserted.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
   localparam logic [3:0] ID_NONE = 4'h1;
   localparam logic [3:0] ID_LSTAT = 4'h6;
   localparam logic [3:0] ID_DATA = 4'h4;
   localparam logic [3:0] ID_TMO = 4'hC;

   localparam logic [2:0] A_DATA = 3'd0;
   localparam logic [2:0] A_IEN = 3'd1;
   localparam logic [2:0] A_ID = 3'd2;
   localparam logic [2:0] A_LCTL = 3'd3;
   localparam logic [2:0] A_LSTAT = 3'd5;

   function automatic logic [4:0] trig_level(input logic [1:0] sel);
      case (sel)
         2'b00: trig_level = 5'd1;
         2'b01: trig_level = 5'd4;
         2'b10: trig_level = 5'd8;
         default: trig_level = 5'd14;
      endcase
   endfunction
endpackage

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
   parameter int DEPTH = 16,
   parameter int WIDTH = 11,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = AW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic [CW-1:0]    fill,
   output logic             empty,
   output logic             full
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("uart_rx_fifo: DEPTH must be a power of two");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr;
   logic             do_push, do_pop;

   assign empty   = (fill == '0);
   assign full    = (fill == CW'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         fill   <= '0;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         fill   <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop) rd_ptr <= rd_ptr + 1'b1;
         fill <= fill + CW'(do_push) - CW'(do_pop);
      end
   end
endmodule

// File: rtl/uart_rx_tmo.sv
module uart_rx_tmo #(
   parameter int CHARS = 4,
   localparam int CNTW = (CHARS < 2) ? 1 : $clog2(CHARS)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic restart,
   input  logic has_data,
   input  logic tick,
   output logic pend
);
   if (CHARS == 0) begin : g_off
      assign pend = 1'b0;
   end else begin : g_on
      localparam logic [CNTW-1:0] LAST = CNTW'(CHARS - 1);
      logic [CNTW-1:0] cnt;
      logic            pend_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt    <= '0;
            pend_q <= 1'b0;
         end else if (clr || restart || !has_data) begin
            cnt    <= '0;
            pend_q <= 1'b0;
         end else if (tick && !pend_q) begin
            if (cnt == LAST) pend_q <= 1'b1;
            else cnt <= cnt + 1'b1;
         end
      end
      assign pend = pend_q;
   end
endmodule

// File: rtl/uart_rx_intid.sv
module uart_rx_intid
   import uart_rx_pkg::*;
(
   input  logic       en_rx,
   input  logic       en_ls,
   input  logic       ls_pend,
   input  logic       data_pend,
   input  logic       tmo_pend,
   output logic [3:0] id,
   output logic       irq
);
   always_comb begin
      id = ID_NONE;
      if (en_ls && ls_pend) id = ID_LSTAT;
      else if (en_rx && data_pend) id = ID_DATA;
      else if (en_rx && tmo_pend) id = ID_TMO;
   end
   assign irq = (en_ls && ls_pend) || (en_rx && (data_pend || tmo_pend));
endmodule

// File: rtl/uart_rx_host.sv
module uart_rx_host
   import uart_rx_pkg::*;
#(
   parameter int FIFO_DEPTH = 16,
   parameter int TMO_CHARS = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cs_n,
   input  logic        rd_n,
   input  logic        wr_n,
   input  logic [2:0]  addr,
   input  logic [7:0]  wdata,
   output logic [7:0]  rdata,
   input  logic        rx_valid,
   input  logic [7:0]  rx_data,
   input  logic [2:0]  rx_err,
   input  logic        char_tick,
   output logic        irq,
   output logic        rxrdy_n,
   output logic [15:0] baud_div
);
   localparam int CW = $clog2(FIFO_DEPTH) + 1;
   localparam int EW = 11;

   if (FIFO_DEPTH < 16) begin : g_bad_depth
      $error("uart_rx_host: FIFO_DEPTH must hold the 14-byte trigger");
   end

   logic          rd_act, wr_act, rd_q, wr_q, rd_pulse, wr_pulse;
   logic [7:0]    lcr, dll, dlh;
   logic [3:0]    ier;
   logic          fifo_en, dma1;
   logic [1:0]    trig_sel;
   logic          dlab, rhr_rd, fifo_clr;
   logic [EW-1:0] head;
   logic [CW-1:0] fill, err_cnt, trig;
   logic          empty, full, tmo_pend, data_pend, ls_pend, err_any, rdy_q;
   logic [2:0]    head_err;
   logic [3:0]    id;
   logic [7:0]    lsr;

   // strobe overlap detection: one access per overlap of select and strobe
   assign rd_act   = !cs_n && !rd_n;
   assign wr_act   = !cs_n && !wr_n;
   assign rd_pulse = rd_act && !rd_q;
   assign wr_pulse = wr_act && !wr_q;
   assign dlab     = lcr[7];
   assign rhr_rd   = rd_pulse && addr == A_DATA && !dlab;
   assign fifo_clr = wr_pulse && addr == A_ID && wdata[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q <= 1'b0;
         wr_q <= 1'b0;
      end else begin
         rd_q <= rd_act;
         wr_q <= wr_act;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lcr      <= '0;
         dll      <= '0;
         dlh      <= '0;
         ier      <= '0;
         fifo_en  <= 1'b0;
         dma1     <= 1'b0;
         trig_sel <= '0;
      end else if (wr_pulse) begin
         case (addr)
            A_DATA: if (dlab) dll <= wdata;
            A_IEN: begin
               if (dlab) dlh <= wdata;
               else ier <= wdata[3:0];
            end
            A_ID: begin
               fifo_en  <= wdata[0];
               dma1     <= wdata[3];
               trig_sel <= wdata[7:6];
            end
            A_LCTL: lcr <= wdata;
            default: ;
         endcase
      end
   end

   uart_rx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(EW)) u_fifo (
      .clk(clk), .rst_n(rst_n), .clr(fifo_clr),
      .push(rx_valid), .din({rx_err, rx_data}),
      .pop(rhr_rd), .dout(head),
      .fill(fill), .empty(empty), .full(full)
   );

   uart_rx_tmo #(.CHARS(TMO_CHARS)) u_tmo (
      .clk(clk), .rst_n(rst_n), .clr(fifo_clr),
      .restart(rhr_rd || rx_valid), .has_data(!empty),
      .tick(char_tick), .pend(tmo_pend)
   );

   // count of queued bytes that carry any error flag
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_cnt <= '0;
      else if (fifo_clr) err_cnt <= '0;
      else err_cnt <= err_cnt + CW'(rx_valid && !full && |rx_err)
                              - CW'(rhr_rd && !empty && |head[10:8]);
   end

   assign err_any   = (err_cnt != '0);
   assign head_err  = empty ? 3'b000 : head[10:8];
   assign trig      = fifo_en ? CW'(trig_level(trig_sel)) : CW'(1);
   assign data_pend = (fill >= trig);
   assign ls_pend   = |head_err;
   assign lsr       = {err_any, 1'b1, 1'b1, head_err, 1'b0, !empty};

   uart_rx_intid u_intid (
      .en_rx(ier[0]), .en_ls(ier[2]),
      .ls_pend(ls_pend), .data_pend(data_pend), .tmo_pend(tmo_pend),
      .id(id), .irq(irq)
   );

   // multi-transfer request: latched at trigger or timeout, released on empty
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdy_q <= 1'b0;
      else if (fifo_clr || empty) rdy_q <= 1'b0;
      else if (data_pend || tmo_pend) rdy_q <= 1'b1;
   end

   always_comb begin
      if (fifo_en && dma1)
         rxrdy_n = !((rdy_q || data_pend || tmo_pend) && !empty && !err_any);
      else
         rxrdy_n = empty;
   end

   always_comb begin
      case (addr)
         A_DATA:  rdata = dlab ? dll : head[7:0];
         A_IEN:   rdata = dlab ? dlh : {4'b0000, ier};
         A_ID:    rdata = {fifo_en, fifo_en, 2'b00, id};
         A_LCTL:  rdata = lcr;
         A_LSTAT: rdata = lsr;
         default: rdata = 8'h00;
      endcase
   end

   assign baud_div = {dlh, dll};
endmodule

// File: rtl/uart_rx_host_chk.sv
module uart_rx_host_chk #(
   parameter int CW = 5,
   parameter int DEPTH = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          irq,
   input logic          rxrdy_n,
   input logic          empty,
   input logic          tmo_pend,
   input logic          rhr_rd,
   input logic [1:0]    ien,
   input logic [CW-1:0] fill,
   input logic          mode1,
   input logic          err_any
);
   AST_TMO_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_pend |-> !empty); // R6
   AST_READ_CLEARS_TMO: assert property (@(posedge clk) disable iff (!rst_n)
      rhr_rd |=> !tmo_pend); // R7
   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (ien == 2'b00) |-> !irq); // R11
   AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= CW'(DEPTH)); // R4
   AST_EMPTY_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> rxrdy_n); // R12
   AST_ERR_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (mode1 && err_any) |-> rxrdy_n); // R13
endmodule

bind uart_rx_host uart_rx_host_chk #(.CW(CW), .DEPTH(FIFO_DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .irq(irq), .rxrdy_n(rxrdy_n),
   .empty(empty), .tmo_pend(tmo_pend), .rhr_rd(rhr_rd),
   .ien({ier[2], ier[0]}), .fill(fill),
   .mode1(fifo_en && dma1), .err_any(err_any)
);

// File: tb/uart_rx_host_bench.sv
module uart_rx_host_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic [2:0]  addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_data = '0;
   logic [2:0]  rx_err = '0;
   logic        char_tick = 1'b0;
   logic        irq, rxrdy_n;
   logic [15:0] baud_div;
   int          errs = 0, checks = 0;
   logic [7:0]  d;

   always #10 clk = ~clk;

   uart_rx_host u_uart_rx_host (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
      .addr(addr), .wdata(wdata), .rdata(rdata),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_err(rx_err),
      .char_tick(char_tick), .irq(irq), .rxrdy_n(rxrdy_n), .baud_div(baud_div)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_rd(input logic [2:0] a, output logic [7:0] v);
      @(negedge clk);
      addr = a; cs_n = 0; rd_n = 0;
      #2 v = rdata;
      @(negedge clk);
      cs_n = 1; rd_n = 1;
   endtask

   task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
      logic [7:0] v;
      bus_rd(a, v);
      chk(req, {8'h00, v}, {8'h00, exp});
   endtask

   task automatic bus_wr(input logic [2:0] a, input logic [7:0] v);
      @(negedge clk);
      addr = a; wdata = v; cs_n = 0; wr_n = 0;
      @(negedge clk);
      cs_n = 1; wr_n = 1;
   endtask

   task automatic push(input logic [7:0] v, input logic [2:0] e);
      @(negedge clk);
      rx_valid = 1; rx_data = v; rx_err = e;
      @(negedge clk);
      rx_valid = 0; rx_err = 0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) char_tick = 1;
         @(negedge clk) char_tick = 0;
      end
   endtask

   task automatic t_reset();
      chk("R1 irq", {15'd0, irq}, 16'd0);
      chk("R1 rxrdy_n", {15'd0, rxrdy_n}, 16'd1);
      rd_chk("R1 iir off", 3'd2, 8'h01);
      rd_chk("R1 lsr idle", 3'd5, 8'h60);
   endtask

   task automatic t_divisor();
      bus_wr(3, 8'h83);
      bus_wr(0, 8'h30);
      bus_wr(1, 8'h12);
      rd_chk("R3 dll", 3'd0, 8'h30);
      rd_chk("R3 dlh", 3'd1, 8'h12);
      chk("R3 baud_div", baud_div, 16'h1230);
      bus_wr(3, 8'h03);
      bus_wr(1, 8'h00);
      rd_chk("R3 ier back", 3'd1, 8'h00);
      chk("R3 div kept", baud_div, 16'h1230);
   endtask

   task automatic t_data_and_timeout();
      bus_wr(2, 8'h41);
      rd_chk("R1 iir fifo", 3'd2, 8'hC1);
      bus_wr(1, 8'h01);
      push(8'h11, 0); push(8'h22, 0); push(8'h33, 0);
      chk("R5 below trig", {15'd0, irq}, 16'd0);
      push(8'h44, 0);
      chk("R5 at trig", {15'd0, irq}, 16'd1);
      rd_chk("R5 iir", 3'd2, 8'hC4);
      rd_chk("R5 data", 3'd0, 8'h11);
      chk("R5 drop", {15'd0, irq}, 16'd0);
      ticks(3);
      chk("R6 early", {15'd0, irq}, 16'd0);
      ticks(1);
      chk("R6 irq", {15'd0, irq}, 16'd1);
      rd_chk("R6 iir", 3'd2, 8'hCC);
      rd_chk("R7 data", 3'd0, 8'h22);
      chk("R7 cleared", {15'd0, irq}, 16'd0);
      rd_chk("R7 data2", 3'd0, 8'h33);
      rd_chk("R8 lsr ready", 3'd5, 8'h61);
      rd_chk("R7 data3", 3'd0, 8'h44);
      rd_chk("R8 lsr empty", 3'd5, 8'h60);
      bus_rd(0, d);
      chk("R7 empty read irq", {15'd0, irq}, 16'd0);
      rd_chk("R7 iir", 3'd2, 8'hC1);
      ticks(6);
      chk("R7 ticks on empty", {15'd0, irq}, 16'd0);
   endtask

   task automatic t_strobes();
      push(8'hA5, 0); push(8'h5A, 0);
      @(negedge clk) begin addr = 0; cs_n = 0; end
      repeat (3) @(negedge clk);
      rd_n = 0;
      #2 chk("R2 head", {8'h00, rdata}, 16'h00A5);
      repeat (3) @(negedge clk);
      rd_n = 1;
      repeat (2) @(negedge clk);
      cs_n = 1;
      rd_chk("R2 single pop", 3'd0, 8'h5A);
      rd_chk("R2 empty", 3'd5, 8'h60);
      push(8'h77, 0);
      @(negedge clk) begin addr = 0; rd_n = 0; end
      repeat (3) @(negedge clk);
      rd_n = 1;
      rd_chk("R2 no cs", 3'd5, 8'h61);
      @(negedge clk) begin addr = 0; rd_n = 0; end
      @(negedge clk) cs_n = 0;
      @(negedge clk) rd_n = 1;
      @(negedge clk) cs_n = 1;
      rd_chk("R2 rd first", 3'd5, 8'h60);
   endtask

   task automatic t_trigger();
      bus_wr(2, 8'hC1);
      for (int i = 0; i < 13; i++) push(8'(i), 0);
      chk("R4 below 14", {15'd0, irq}, 16'd0);
      push(8'hEE, 0);
      chk("R4 at 14", {15'd0, irq}, 16'd1);
      bus_wr(2, 8'hC3);
      rd_chk("R4 reset lsr", 3'd5, 8'h60);
      chk("R4 reset irq", {15'd0, irq}, 16'd0);
      bus_wr(2, 8'h01);
      push(8'h01, 0);
      chk("R4 trig 1", {15'd0, irq}, 16'd1);
      bus_rd(0, d);
   endtask

   task automatic t_line_status();
      bus_wr(2, 8'h41);
      bus_wr(1, 8'h05);
      push(8'h10, 3'b001);
      rd_chk("R9 parity head", 3'd5, 8'hE5);
      chk("R10 irq", {15'd0, irq}, 16'd1);
      rd_chk("R10 iir", 3'd2, 8'hC6);
      push(8'h01, 0); push(8'h02, 0); push(8'h03, 0);
      rd_chk("R10 priority", 3'd2, 8'hC6);
      rd_chk("R9 err data", 3'd0, 8'h10);
      rd_chk("R9 clean head", 3'd5, 8'h61);
      push(8'h20, 3'b100);
      rd_chk("R9 queued err", 3'd5, 8'hE1);
      rd_chk("R5 iir", 3'd2, 8'hC4);
      bus_rd(0, d); bus_rd(0, d); bus_rd(0, d);
      rd_chk("R9 break head", 3'd5, 8'hF1);
      rd_chk("R10 iir break", 3'd2, 8'hC6);
      rd_chk("R9 break data", 3'd0, 8'h20);
      rd_chk("R8 drained", 3'd5, 8'h60);
      bus_wr(1, 8'h00);
      push(8'h30, 3'b010);
      chk("R11 masked", {15'd0, irq}, 16'd0);
      bus_wr(1, 8'h04);
      chk("R11 enabled", {15'd0, irq}, 16'd1);
      bus_wr(2, 8'h43);
      chk("R11 cleared", {15'd0, irq}, 16'd0);
   endtask

   task automatic t_dma();
      bus_wr(1, 8'h00);
      bus_wr(2, 8'h41);
      push(8'h55, 0);
      chk("R12 low", {15'd0, rxrdy_n}, 16'd0);
      bus_rd(0, d);
      chk("R12 high", {15'd0, rxrdy_n}, 16'd1);
      bus_wr(2, 8'h49);
      push(8'h01, 0); push(8'h02, 0); push(8'h03, 0);
      chk("R13 below trig", {15'd0, rxrdy_n}, 16'd1);
      push(8'h04, 0);
      chk("R13 trig", {15'd0, rxrdy_n}, 16'd0);
      bus_rd(0, d); bus_rd(0, d); bus_rd(0, d);
      chk("R13 held", {15'd0, rxrdy_n}, 16'd0);
      bus_rd(0, d);
      chk("R13 empty", {15'd0, rxrdy_n}, 16'd1);
      push(8'h09, 0);
      ticks(4);
      chk("R13 timeout", {15'd0, rxrdy_n}, 16'd0);
      bus_rd(0, d);
      chk("R13 timeout drained", {15'd0, rxrdy_n}, 16'd1);
      push(8'h01, 0); push(8'h02, 3'b010); push(8'h03, 0); push(8'h04, 0);
      chk("R13 error", {15'd0, rxrdy_n}, 16'd1);
      bus_wr(2, 8'h4B);
   endtask

   initial begin
      #(200000 * 20);
      errs++; checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_divisor();
      t_data_and_timeout();
      t_strobes();
      t_trigger();
      t_line_status();
      t_dma();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule